// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block forms the byte a flash array returns to a status read while an automatic program or erase is running, while a sector-erase command window is still open, or while an erase is suspended. The sequencer that runs the operation lives elsewhere. It tells this block which operation is in progress, which byte is being written, which sectors are being erased, which sectors failed, whether the internal time limit has been exceeded, and whether the sector-erase window is still open. The block holds two toggle flip-flops that advance on status reads. It drives a polling bit, a general toggle bit, a time-limit bit, a window bit and an address-qualified toggle bit. When status is not selected, or no operation is active, it passes the array data through unchanged.

The operation code is registered into a small state machine. Its states are ST_IDLE, ST_PROG, ST_CHIP, ST_SWIN (sector erase, window open), ST_SRUN (sector erase, window closed) and ST_SUSP (erase suspended). On every clock edge the next state comes from the operation code alone, so every transition between any two states is taken directly: IDLE->PROG, SRUN->SUSP, SUSP->PROG, any->IDLE and so on. Within a sector erase, ST_SWIN and ST_SRUN swap as the window flag changes. Status reads are single-cycle strobes. The toggles flip at the clock edge that samples the strobe, so a strobed read sees the old value and the next read sees the inverted one.

Top module: `flash_status_gen`

## Requirements
- R1: With `status_sel` low, or in ST_IDLE, `dout` equals `array_data`.
- R2: In ST_PROG, bit 7 is the inverse of `prog_byte[7]`, bit 3 is 0 and bit 2 holds its value.
- R3: In ST_CHIP, ST_SWIN and ST_SRUN, bit 7 reads 0.
- R4: In ST_PROG, ST_CHIP, ST_SWIN and ST_SRUN, bit 6 inverts after every status read (`rd_stb` with `status_sel` high).
- R5: In those four states, bit 5 equals `time_fail`, and bit 6 keeps toggling while it is set.
- R6: Bit 3 reads 0 in ST_SWIN and 1 in ST_SRUN and ST_CHIP.
- R7: In ST_SWIN and ST_SRUN with `time_fail` low, bit 2 inverts after a status read only when the addressed sector has its `erase_mask` bit set. The sector index is the top log2(SECTORS) bits of `rd_addr`.
- R8: In ST_CHIP with `time_fail` low, bit 2 inverts after every status read at any address.
- R9: In chip or sector erase with `time_fail` high, bit 2 inverts only for addresses in a sector whose `fail_mask` bit is set.
- R10: In ST_SUSP, a status read of an erasing sector returns bit 7 = 1, bits 5 and 3 = 0 and bit 6 held, and bit 2 inverts after the read. A status read of any other sector returns `array_data`.
- R11: Both toggles read 0 after any cycle spent in ST_IDLE. In every status byte, bits 4, 1 and 0 are 0.
- R12: `op_kind` encoding: 0 = none, 1 = program, 2 = chip erase, 3 = sector erase (`window_open` high selects ST_SWIN, low selects ST_SRUN), 4 = suspended, and 5 to 7 = none. The state follows one clock after `op_kind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_kind | input | 3 | Operation in progress (encoding in R12) |
| window_open | input | 1 | Sector-erase command window still open |
| prog_byte | input | 8 | Byte being programmed |
| time_fail | input | 1 | Internal time limit exceeded |
| erase_mask | input | SECTORS | Sectors selected for erase |
| fail_mask | input | SECTORS | Sectors that failed |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| status_sel | input | 1 | Read returns status rather than raw data |
| array_data | input | 8 | Raw array data for the current address |
| dout | output | 8 | Read data / status byte |

## Verification
The bench builds the block with ADDR_W = 10 and SECTORS = 4. With these values, random addresses land in every sector often, and random erase and fail masks with four bits often produce both hit and miss cases for the bit-2 qualification. Keeping the operation code steady for many cycles at a time allows long runs of toggling within one state. Random codes 5 to 7 exercise the fall-back to idle and the clearing of both toggles.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    localparam logic [2:0] OPK_NONE = 3'd0;
    localparam logic [2:0] OPK_PROG = 3'd1;
    localparam logic [2:0] OPK_CHIP = 3'd2;
    localparam logic [2:0] OPK_SECT = 3'd3;
    localparam logic [2:0] OPK_SUSP = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PROG = 3'd1,
        ST_CHIP = 3'd2,
        ST_SWIN = 3'd3,
        ST_SRUN = 3'd4,
        ST_SUSP = 3'd5
    } st_t;

endpackage

// File: rtl/stat_fsm.sv
module stat_fsm
    import flash_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op_kind,
    input  logic       window_open,
    output st_t        state
);

    st_t state_nx;

    always_comb begin
        state_nx = ST_IDLE;
        unique case (op_kind)
            OPK_PROG: state_nx = ST_PROG;
            OPK_CHIP: state_nx = ST_CHIP;
            OPK_SECT: state_nx = window_open ? ST_SWIN : ST_SRUN;
            OPK_SUSP: state_nx = ST_SUSP;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/stat_sector_hit.sv
module stat_sector_hit #(
    parameter int ADDR_W  = 19,
    parameter int SECTORS = 8
) (
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [SECTORS-1:0] erase_mask,
    input  logic [SECTORS-1:0] fail_mask,
    output logic               in_erase,
    output logic               in_fail
);

    localparam int SW = (SECTORS > 1) ? $clog2(SECTORS) : 1;

    logic [SW-1:0]      idx;
    logic [SECTORS-1:0] onehot;

    assign idx = rd_addr[ADDR_W-1 -: SW];

    generate
        for (genvar s = 0; s < SECTORS; s++) begin : g_dec
            assign onehot[s] = (idx == SW'(s));
        end
    endgenerate

    assign in_erase = |(onehot & erase_mask);
    assign in_fail  = |(onehot & fail_mask);

endmodule

// File: rtl/stat_toggle.sv
module stat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic flip,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (clear) q <= 1'b0;
        else if (flip)  q <= ~q;
    end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_stat_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int SECTORS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op_kind,
    input  logic               window_open,
    input  logic [7:0]         prog_byte,
    input  logic               time_fail,
    input  logic [SECTORS-1:0] erase_mask,
    input  logic [SECTORS-1:0] fail_mask,
    input  logic               rd_stb,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               status_sel,
    input  logic [7:0]         array_data,
    output logic [7:0]         dout
);

    st_t  state;
    logic in_erase, in_fail;
    logic tog6, tog2;
    logic run6, run2, rd_status, clr;

    stat_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_kind     (op_kind),
        .window_open (window_open),
        .state       (state)
    );

    stat_sector_hit #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) u_hit (
        .rd_addr    (rd_addr),
        .erase_mask (erase_mask),
        .fail_mask  (fail_mask),
        .in_erase   (in_erase),
        .in_fail    (in_fail)
    );

    // qualification of the two toggles per state
    always_comb begin
        run6 = 1'b0;
        run2 = 1'b0;
        unique case (state)
            ST_IDLE: begin
                run6 = 1'b0;
                run2 = 1'b0;
            end
            ST_PROG: begin
                run6 = 1'b1;
                run2 = 1'b0;
            end
            ST_CHIP: begin
                run6 = 1'b1;
                run2 = time_fail ? in_fail : 1'b1;
            end
            ST_SWIN, ST_SRUN: begin
                run6 = 1'b1;
                run2 = time_fail ? in_fail : in_erase;
            end
            ST_SUSP: begin
                run6 = 1'b0;
                run2 = in_erase;
            end
            default: begin
                run6 = 1'b0;
                run2 = 1'b0;
            end
        endcase
    end

    assign rd_status = rd_stb & status_sel;
    assign clr       = (state == ST_IDLE);

    stat_toggle u_t6 (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr),
        .flip  (rd_status & run6),
        .q     (tog6)
    );

    stat_toggle u_t2 (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr),
        .flip  (rd_status & run2),
        .q     (tog2)
    );

    // output byte per state
    always_comb begin
        dout = array_data;
        if (status_sel) begin
            unique case (state)
                ST_IDLE: dout = array_data;
                ST_PROG: dout = {~prog_byte[7], tog6, time_fail, 1'b0, 1'b0, tog2, 2'b00};
                ST_CHIP: dout = {1'b0, tog6, time_fail, 1'b0, 1'b1, tog2, 2'b00};
                ST_SWIN: dout = {1'b0, tog6, time_fail, 1'b0, 1'b0, tog2, 2'b00};
                ST_SRUN: dout = {1'b0, tog6, time_fail, 1'b0, 1'b1, tog2, 2'b00};
                ST_SUSP: dout = in_erase ? {1'b1, tog6, 1'b0, 1'b0, 1'b0, tog2, 2'b00}
                                         : array_data;
                default: dout = array_data;
            endcase
        end
    end

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk
    import flash_stat_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       status_sel,
    input logic       rd_stb,
    input logic [7:0] array_data,
    input logic [7:0] prog_byte,
    input logic [7:0] dout,
    input st_t        state,
    input logic       tog6,
    input logic       tog2
);

    AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !status_sel |-> dout == array_data); // R1

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (status_sel && state == ST_PROG) |-> (dout[7] == ~prog_byte[7] && !dout[3])); // R2

    AST_PROG_T2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PROG |=> $stable(tog2)); // R2

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (status_sel && state inside {ST_CHIP, ST_SWIN, ST_SRUN}) |-> !dout[7]); // R3

    AST_T6_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && status_sel && state inside {ST_PROG, ST_CHIP, ST_SWIN, ST_SRUN})
        |=> tog6 != $past(tog6)); // R4

    AST_SUSP_T6_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SUSP |=> $stable(tog6)); // R10

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |=> (!tog6 && !tog2)); // R11

    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_sel && state inside {ST_PROG, ST_CHIP, ST_SWIN, ST_SRUN})
        |-> (!dout[4] && dout[1:0] == 2'b00)); // R11

endmodule

bind flash_status_gen flash_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_sel (status_sel),
    .rd_stb     (rd_stb),
    .array_data (array_data),
    .prog_byte  (prog_byte),
    .dout       (dout),
    .state      (state),
    .tog6       (tog6),
    .tog2       (tog2)
);

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;

    localparam int AW = 10;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_kind = 3'd0;
    logic          window_open = 1'b0;
    logic [7:0]    prog_byte = 8'h00;
    logic          time_fail = 1'b0;
    logic [NS-1:0] erase_mask = '0;
    logic [NS-1:0] fail_mask = '0;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          status_sel = 1'b0;
    logic [7:0]    array_data = 8'h00;
    logic [7:0]    dout;

    int checks = 0;
    int errors = 0;

    // bench model: 0 idle,1 prog,2 chip,3 window,4 running,5 suspended
    int   m_st = 0;
    logic m_t6 = 1'b0;
    logic m_t2 = 1'b0;

    flash_status_gen #(.ADDR_W(AW), .SECTORS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .window_open(window_open),
        .prog_byte(prog_byte), .time_fail(time_fail), .erase_mask(erase_mask),
        .fail_mask(fail_mask), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .status_sel(status_sel), .array_data(array_data), .dout(dout)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int decode(input logic [2:0] op, input logic win);
        case (op)
            3'd1: return 1;
            3'd2: return 2;
            3'd3: return win ? 3 : 4;
            3'd4: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic sec_erase();
        return erase_mask[rd_addr[AW-1 -: 2]];
    endfunction

    function automatic logic sec_fail();
        return fail_mask[rd_addr[AW-1 -: 2]];
    endfunction

    function automatic logic [7:0] expect_out();
        if (!status_sel) return array_data;
        case (m_st)
            1: return {~prog_byte[7], m_t6, time_fail, 2'b00, m_t2, 2'b00};
            2: return {1'b0, m_t6, time_fail, 1'b0, 1'b1, m_t2, 2'b00};
            3: return {1'b0, m_t6, time_fail, 1'b0, 1'b0, m_t2, 2'b00};
            4: return {1'b0, m_t6, time_fail, 1'b0, 1'b1, m_t2, 2'b00};
            5: return sec_erase() ? {1'b1, m_t6, 3'b000, m_t2, 2'b00} : array_data;
            default: return array_data;
        endcase
    endfunction

    function automatic string tag_of();
        if (!status_sel) return "R1";
        case (m_st)
            1: return "R2/R4/R5";
            2: return "R3/R6/R8/R9";
            3: return "R6/R7";
            4: return "R6/R7/R9";
            5: return "R10";
            default: return "R11/R12";
        endcase
    endfunction

    // model step on the inputs present before the edge
    task automatic tick();
        logic rs, f6, f2;
        int nx;
        rs = rd_stb & status_sel;
        f6 = rs && (m_st >= 1 && m_st <= 4);
        case (m_st)
            2: f2 = rs && (time_fail ? sec_fail() : 1'b1);
            3, 4: f2 = rs && (time_fail ? sec_fail() : sec_erase());
            5: f2 = rs && sec_erase();
            default: f2 = 1'b0;
        endcase
        nx = decode(op_kind, window_open);
        @(posedge clk);
        if (m_st == 0) begin
            m_t6 = 1'b0;
            m_t2 = 1'b0;
        end else begin
            if (f6) m_t6 = ~m_t6;
            if (f2) m_t2 = ~m_t2;
        end
        m_st = nx;
        #1;
    endtask

    task automatic chk_byte(input string tag, input logic [7:0] exp);
        #1;
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, dout, exp);
        end
    endtask

    task automatic chk_model();
        chk_byte(tag_of(), expect_out());
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();

        // reset / idle passthrough: R1, R11
        status_sel = 1'b1; array_data = 8'h5A;
        chk_byte("R1 idle passthrough", 8'h5A);

        // program: R2, R4, R5, R12 latency
        op_kind = 3'd1; prog_byte = 8'h80;
        chk_byte("R12 state lags op_kind", 8'h5A);
        tick();
        chk_byte("R2 program poll", 8'h00);
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk_byte("R4 bit6 after one read", 8'h40);
        time_fail = 1'b1; rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk_byte("R5 fail and toggle", 8'h20);
        status_sel = 1'b0; array_data = 8'hC3;
        chk_byte("R1 raw while programming", 8'hC3);
        status_sel = 1'b1; time_fail = 1'b0;

        // chip erase: R3, R6, R8, R9
        op_kind = 3'd0; tick();
        op_kind = 3'd2; tick();
        chk_byte("R6 chip erase bit3", 8'h08);
        rd_addr = 10'h000; rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk_byte("R8 chip bit2 any address", 8'h4C);
        time_fail = 1'b1; fail_mask = 4'b0100; rd_addr = 10'h100;
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk_byte("R9 non-failing sector holds bit2", 8'h2C);
        rd_addr = 10'h200; rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk_byte("R9 failing sector flips bit2", 8'h68);
        time_fail = 1'b0;

        // sector erase window: R6, R7
        op_kind = 3'd0; tick();
        op_kind = 3'd3; window_open = 1'b1; erase_mask = 4'b1000; tick();
        chk_byte("R6 window open bit3", 8'h00);
        rd_addr = 10'h000; rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk_byte("R7 non-erasing sector holds bit2", 8'h40);
        rd_addr = 10'h3FF; rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk_byte("R7 erasing sector flips bit2", 8'h04);
        window_open = 1'b0; tick();
        chk_byte("R6 window closed bit3", 8'h0C);

        // suspend: R10
        op_kind = 3'd4; tick();
        chk_byte("R10 erasing sector read", 8'h84);
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk_byte("R10 bit6 held bit2 flips", 8'h80);
        rd_addr = 10'h080; array_data = 8'h3C;
        chk_byte("R10 other sector raw", 8'h3C);

        // undefined code -> idle, toggles cleared: R12, R11
        op_kind = 3'd6; tick();
        chk_byte("R12 code 6 idles", 8'h3C);
        op_kind = 3'd2; tick();
        chk_byte("R11 toggles cleared after idle", 8'h08);

        // random phase
        void'($urandom(32'd7341));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) op_kind = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 5) == 0) window_open = ~window_open;
            if ($urandom_range(0, 9) == 0) time_fail = ~time_fail;
            if ($urandom_range(0, 15) == 0) erase_mask = NS'($urandom);
            if ($urandom_range(0, 15) == 0) fail_mask = NS'($urandom);
            prog_byte  = 8'($urandom);
            array_data = 8'($urandom);
            rd_addr    = AW'($urandom);
            rd_stb     = ($urandom_range(0, 2) != 0);
            status_sel = ($urandom_range(0, 5) != 0);
            chk_model();
            tick();
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule